// File: doc/BRIEF.md
# Ethernet Controller Command and Interrupt Register File

This block is the register file that a host processor sees on an Ethernet controller. All registers are 16-bit words on a simple synchronous bus. A write takes effect at the clock edge where `reg_wr` is high. Reads are combinational from the addressed register.

The block holds the following registers:
- the command register;
- the interrupt mask and interrupt status registers;
- a set of configuration, control, ring-pointer and error-tally registers. Each of these applies its own write rule.

Writes to the command register become one-cycle start pulses for the transmit, address-filter-load and receive-resource-fetch engines. Those engines, together with the receive path and the watchdog timer, report back through single-cycle event inputs. Each event sets a status bit, and a done event also retires its command bit. A single level interrupt output is raised whenever an unmasked status bit is set.

The word address map is:

| Address | Register |
|---|---|
| 0x00 | command |
| 0x01 | data configuration |
| 0x02 | receive control |
| 0x03 | transmit control |
| 0x04 | interrupt mask |
| 0x05 | interrupt status |
| 0x06 | ring start pointer |
| 0x07 | ring end pointer |
| 0x08 | ring read pointer |
| 0x09 | ring write pointer |
| 0x0A | CRC error tally |
| 0x0B | alignment error tally |
| 0x0C | missed packet tally |
| 0x0D | end-of-buffer count |

Any other address reads 0 and ignores writes.

Top module: `nic_ctl_regs`

## Requirements
- R1: After hardware reset, the command register (addr 0x00) reads 0x0094, which is reset 0x0080, stop-timer 0x0010 and RX-disable 0x0004. The mask (0x04) and status (0x05) registers read 0, the end-of-buffer count (0x0D) reads 0x02F8, and `irq` is low.
- R2: `irq` is high exactly when the mask register and the status register have a common set bit. A write to the mask register stores bits 14:0 and reads back bit 15 as 0.
- R3: A write to the status register clears only those written-1 bits that are currently set. When such a write clears bit 0x0020, `rra_start` is high for the one cycle after the write. Writing 1 to bit 0x0020 while that bit is clear gives no pulse.
- R4: The event inputs set status bits as follows: `ev_rbuf_exh` sets 0x0020, `ev_rdesc_exh` sets 0x0040, `ev_timer_uf` sets 0x0080, `ev_rx_pkt` sets 0x0400 and `ev_prog_int` sets 0x0800. An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R5: A command write ORs its data into the command register through mask 0x03BF. Command bits 0x0002 (transmit), 0x0200 (load filter) and 0x0100 (fetch resource) each give a one-cycle pulse on `tx_start`, `cam_start` or `rra_start` respectively, in the cycle after the write.
- R6: While command bit 0x0080 is set, a command write with bit 0x0080 clear only clears that bit. Every other command bit is unchanged and no start pulse is produced.
- R7: Writing RX-enable (0x0008) clears RX-disable (0x0004), and writing RX-disable clears RX-enable. Writing start-timer (0x0020) clears stop-timer (0x0010), and writing stop-timer clears start-timer.
- R8: A command write with 0x0080 set clears bits 0x0200, 0x0100, 0x0002 and 0x0001, sets 0x0080 and 0x0004, and produces no start pulse.
- R9: `tx_done` clears command bit 0x0002 and sets status bit 0x0200. `cam_done` clears command bit 0x0200 and sets status bit 0x1000. `rra_done` clears command bit 0x0100. Each takes effect at the same clock edge.
- R10: The data configuration register (0x01) stores the written value ANDed with 0xBFFF, but only while command bit 0x0080 is set. At other times writes to it are ignored.
- R11: The transmit control register (0x03) keeps only bits 15:12 of a write, and the receive control register (0x02) keeps only bits 15:5.
- R12: The four ring pointers (0x06 to 0x09) store the written value with bit 0 forced to 0. The three tallies (0x0A to 0x0C) store the bitwise inverse of the written value. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| reg_addr | input | AW | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| ev_rbuf_exh | input | 1 | Receive buffers exhausted event |
| ev_rdesc_exh | input | 1 | Receive descriptors exhausted event |
| ev_timer_uf | input | 1 | Watchdog timer underflow event |
| ev_rx_pkt | input | 1 | Packet received event |
| ev_prog_int | input | 1 | Programmable interrupt event |
| tx_done | input | 1 | Transmit engine finished |
| cam_done | input | 1 | Address filter load finished |
| rra_done | input | 1 | Receive resource fetch finished |
| tx_start | output | 1 | Transmit start pulse |
| cam_start | output | 1 | Address filter load start pulse |
| rra_start | output | 1 | Receive resource fetch start pulse |
| irq | output | 1 | Level interrupt request |

## Verification
A command bit left set or cleared wrongly shows on a read of address 0x00 right after the edge that caused it. It also shows as a missing or extra start pulse in the next cycle. A corrupted status or mask register shows on `irq` in the same cycle, because the interrupt is decoded combinationally from the two stored words. The reset-exit and software-reset paths are checked directly after the write, because a mistake there would only show up later as a lost or spurious engine start.

// File: rtl/nic_ctl_regs.sv
module nic_ctl_regs #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          ev_rbuf_exh,
  input  logic          ev_rdesc_exh,
  input  logic          ev_timer_uf,
  input  logic          ev_rx_pkt,
  input  logic          ev_prog_int,
  input  logic          tx_done,
  input  logic          cam_done,
  input  logic          rra_done,
  output logic          tx_start,
  output logic          cam_start,
  output logic          rra_start,
  output logic          irq
);
  localparam logic [AW-1:0] A_CMD = AW'(0),  A_DCFG = AW'(1),  A_RXC = AW'(2),
                            A_TXC = AW'(3),  A_IMSK = AW'(4),  A_ISTA = AW'(5),
                            A_PRS = AW'(6),  A_PRE = AW'(7),   A_PRR = AW'(8),
                            A_PRW = AW'(9),  A_TCRC = AW'(10), A_TALN = AW'(11),
                            A_TMIS = AW'(12), A_EOBC = AW'(13);
  localparam int NPTR = 4;
  localparam int NTAL = 3;

  logic [15:0] cmd_q, dcfg_q, rxc_q, txc_q, imsk_q, ista_q, eobc_q;
  logic [15:0] ptr_q [NPTR];
  logic [15:0] tal_q [NTAL];
  logic [15:0] cmd_n, ista_n, clr_v, ev_v;
  logic        cmd_wr, rst_exit, cmd_go;

  assign cmd_wr   = reg_wr && reg_addr == A_CMD;
  assign rst_exit = cmd_q[7] && !reg_wdata[7];
  assign cmd_go   = cmd_wr && !rst_exit && !reg_wdata[7];
  assign clr_v    = (reg_wr && reg_addr == A_ISTA) ? (reg_wdata & ista_q) : 16'h0;
  assign ev_v     = {3'b0, cam_done, ev_prog_int, ev_rx_pkt, tx_done, 1'b0,
                     ev_timer_uf, ev_rdesc_exh, ev_rbuf_exh, 5'b0};
  assign ista_n   = (ista_q & ~clr_v) | ev_v;
  assign irq      = |(imsk_q & ista_q);

  always_comb begin
    cmd_n = cmd_q;
    if (cmd_wr) begin
      if (rst_exit) cmd_n[7] = 1'b0;
      else begin
        cmd_n = cmd_q | (reg_wdata & 16'h03BF);
        if (reg_wdata[2]) cmd_n[3] = 1'b0;
        if (reg_wdata[3]) cmd_n[2] = 1'b0;
        if (reg_wdata[4]) cmd_n[5] = 1'b0;
        if (reg_wdata[5]) cmd_n[4] = 1'b0;
        if (reg_wdata[7]) cmd_n = (cmd_n & ~16'h0303) | 16'h0084;
      end
    end
    if (tx_done)  cmd_n[1] = 1'b0;
    if (cam_done) cmd_n[9] = 1'b0;
    if (rra_done) cmd_n[8] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= 16'h0094; dcfg_q <= '0; rxc_q <= '0; txc_q <= '0;
      imsk_q <= '0; ista_q <= '0; eobc_q <= 16'h02F8;
      tx_start <= 1'b0; cam_start <= 1'b0; rra_start <= 1'b0;
    end else begin
      cmd_q     <= cmd_n;
      ista_q    <= ista_n;
      tx_start  <= cmd_go && reg_wdata[1];
      cam_start <= cmd_go && reg_wdata[9];
      rra_start <= (cmd_go && reg_wdata[8]) || clr_v[5];
      if (reg_wr) begin
        case (reg_addr)
          A_DCFG: if (cmd_q[7]) dcfg_q <= reg_wdata & 16'hBFFF;
          A_RXC:  rxc_q  <= reg_wdata & 16'hFFE0;
          A_TXC:  txc_q  <= reg_wdata & 16'hF000;
          A_IMSK: imsk_q <= reg_wdata & 16'h7FFF;
          A_EOBC: eobc_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n) ptr_q[g] <= '0;
      else if (reg_wr && reg_addr == A_PRS + AW'(g)) ptr_q[g] <= reg_wdata & 16'hFFFE;
    end
  end

  for (genvar g = 0; g < NTAL; g++) begin : g_tal
    always_ff @(posedge clk) begin
      if (!rst_n) tal_q[g] <= '0;
      else if (reg_wr && reg_addr == A_TCRC + AW'(g)) tal_q[g] <= ~reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CMD:  reg_rdata = cmd_q;
      A_DCFG: reg_rdata = dcfg_q;
      A_RXC:  reg_rdata = rxc_q;
      A_TXC:  reg_rdata = txc_q;
      A_IMSK: reg_rdata = imsk_q;
      A_ISTA: reg_rdata = ista_q;
      A_PRS:  reg_rdata = ptr_q[0];
      A_PRE:  reg_rdata = ptr_q[1];
      A_PRR:  reg_rdata = ptr_q[2];
      A_PRW:  reg_rdata = ptr_q[3];
      A_TCRC: reg_rdata = tal_q[0];
      A_TALN: reg_rdata = tal_q[1];
      A_TMIS: reg_rdata = tal_q[2];
      A_EOBC: reg_rdata = eobc_q;
      default: reg_rdata = 16'h0;
    endcase
  end

  AST_RBE_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ISTA && reg_wdata[5] && ista_q[5]) |=> rra_start); // R3
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_pkt |=> ista_q[10]); // R4
  AST_RST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_q[7] && !reg_wdata[7] && !tx_done && !cam_done && !rra_done)
    |=> (!cmd_q[7] && cmd_q[6:0] == $past(cmd_q[6:0]) && cmd_q[15:8] == $past(cmd_q[15:8])
         && !tx_start && !cam_start && !rra_start)); // R6
  AST_TIMER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_q[4] && cmd_q[5])); // R7
  AST_SWRST_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && reg_wdata[7]) |=> (cmd_q[7] && cmd_q[2] && !tx_start && !cam_start)); // R8
  AST_TXDONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (!cmd_q[1] && ista_q[9])); // R9
  AST_DCFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DCFG && !cmd_q[7]) |=> $stable(dcfg_q)); // R10
endmodule

// File: tb/sim_nic_ctl_regs.sv
`timescale 1ns/1ps
module sim_nic_ctl_regs;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [5:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic ev_rbuf_exh = 0, ev_rdesc_exh = 0, ev_timer_uf = 0, ev_rx_pkt = 0, ev_prog_int = 0;
  logic tx_done = 0, cam_done = 0, rra_done = 0;
  logic tx_start, cam_start, rra_start, irq;

  nic_ctl_regs #(.AW(6)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_rbuf_exh(ev_rbuf_exh), .ev_rdesc_exh(ev_rdesc_exh), .ev_timer_uf(ev_timer_uf),
    .ev_rx_pkt(ev_rx_pkt), .ev_prog_int(ev_prog_int),
    .tx_done(tx_done), .cam_done(cam_done), .rra_done(rra_done),
    .tx_start(tx_start), .cam_start(cam_start), .rra_start(rra_start), .irq(irq));

  typedef struct { logic [15:0] act; logic [15:0] exp; string tag; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit all_pushed = 0, finished = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if (it.act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got 0x%04h expected 0x%04h", it.tag, it.act, it.exp);
      end
    end
  end

  task automatic push(input logic [15:0] act, input logic [15:0] exp, input string tag);
    item_t it;
    it.act = act; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
    reg_addr = a;
    #1;
    push(reg_rdata, exp, tag);
  endtask

  task automatic pulses(input logic [2:0] exp, input string tag);
    push({13'b0, tx_start, cam_start, rra_start}, {13'b0, exp}, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0x0000 expected 0x0001");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, 16'h0094, "R1 cmd reset");
    rd(4, 16'h0000, "R1 mask reset");
    rd(5, 16'h0000, "R1 status reset");
    rd(13, 16'h02F8, "R1 eob count reset");
    push({15'b0, irq}, 16'h0, "R1 irq reset");

    wr(1, 16'hFFFF); rd(1, 16'hBFFF, "R10 dcfg write in reset");
    wr(6, 16'h1235); rd(6, 16'h1234, "R12 ring start ptr");
    wr(9, 16'hFFFF); rd(9, 16'hFFFE, "R12 ring write ptr");
    wr(10, 16'h00F0); rd(10, 16'hFF0F, "R12 crc tally inverted");
    wr(12, 16'h1234); rd(12, 16'hEDCB, "R12 missed tally inverted");
    rd(6'h3F, 16'h0000, "R12 unmapped read");
    wr(3, 16'hFFFF); rd(3, 16'hF000, "R11 txctl mask");
    wr(2, 16'hFFFF); rd(2, 16'hFFE0, "R11 rxctl mask");

    wr(0, 16'h0002);
    pulses(3'b000, "R6 no pulse on reset exit");
    rd(0, 16'h0014, "R6 only reset bit clears");
    wr(1, 16'h0001); rd(1, 16'hBFFF, "R10 dcfg locked out of reset");

    wr(0, 16'h0002);
    pulses(3'b100, "R5 tx_start pulse");
    rd(0, 16'h0016, "R5 transmit bit set");
    @(negedge clk); pulses(3'b000, "R5 pulse is one cycle");

    tx_done = 1; @(negedge clk); tx_done = 0;
    rd(0, 16'h0014, "R9 tx_done clears cmd");
    rd(5, 16'h0200, "R9 tx_done sets status");
    push({15'b0, irq}, 16'h0, "R2 masked irq low");
    wr(4, 16'hFFFF); rd(4, 16'h7FFF, "R2 mask drops bit 15");
    push({15'b0, irq}, 16'h1, "R2 irq high");

    wr(5, 16'h0400); rd(5, 16'h0200, "R3 clear of unset bit");
    wr(5, 16'h0020); pulses(3'b000, "R3 no pulse for clear bit");
    wr(5, 16'h0200); rd(5, 16'h0000, "R3 clear set bit");
    push({15'b0, irq}, 16'h0, "R2 irq low after clear");

    ev_rbuf_exh = 1; ev_rdesc_exh = 1; ev_timer_uf = 1; ev_rx_pkt = 1; ev_prog_int = 1;
    @(negedge clk);
    ev_rbuf_exh = 0; ev_rdesc_exh = 0; ev_timer_uf = 0; ev_rx_pkt = 0; ev_prog_int = 0;
    rd(5, 16'h0CE0, "R4 event bit positions");
    wr(5, 16'h0020);
    pulses(3'b001, "R3 rra pulse on exhausted clear");
    rd(5, 16'h0CC0, "R3 exhausted bit cleared");
    ev_rx_pkt = 1; wr(5, 16'h0400); ev_rx_pkt = 0;
    rd(5, 16'h0CC0, "R4 event wins over clear");

    wr(0, 16'h0008); rd(0, 16'h0018, "R7 rx enable clears disable");
    wr(0, 16'h0020); rd(0, 16'h0028, "R7 start clears stop");
    wr(0, 16'h0004); rd(0, 16'h0024, "R7 rx disable clears enable");

    wr(0, 16'h0200);
    pulses(3'b010, "R5 cam_start pulse");
    rd(0, 16'h0224, "R5 load bit set");
    cam_done = 1; @(negedge clk); cam_done = 0;
    rd(0, 16'h0024, "R9 cam_done clears cmd");
    rd(5, 16'h1CC0, "R9 cam_done sets status");

    wr(0, 16'h0100);
    pulses(3'b001, "R5 rra_start pulse");
    rra_done = 1; @(negedge clk); rra_done = 0;
    rd(0, 16'h0024, "R9 rra_done clears cmd");

    wr(0, 16'h0002);
    wr(0, 16'h0083);
    pulses(3'b000, "R8 no pulse on soft reset");
    rd(0, 16'h00A4, "R8 soft reset bits");

    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule